// File: doc/BRIEF.md
# Embedded Controller Command Sequencer

This block is a host-side master that carries out one complete command exchange with an embedded controller. The controller has two byte ports on a small request/acknowledge bus. One is a status/command port at address 0x6C. The other is a data port at 0x68. A single `start` strobe latches a command byte, an argument list with its length, a response length and a timeout in milliseconds. The block then runs the whole exchange without further help from the host.

Before it sends anything, the sequencer empties any stale output byte the controller is still holding. It then waits for the controller's input buffer to drain, writes the command and writes each argument. Last, it collects the requested number of response bytes. Every wait polls the status register once per millisecond; a millisecond is `TICK_CYCLES` clock cycles. If the input buffer stays full, the exchange is abandoned. If an expected response byte never appears, the whole command is sent again, up to a bounded number of times.

Top module: `ec_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `slow_warn` and `bus_req` are low and `resp_valid_cnt` is 0.
- R2: A `start` seen while idle latches all request inputs and raises `busy` on the next cycle. A `start` while `busy` is high is ignored: the running command is unchanged and no second exchange follows.
- R3: The block reads status at 0x6C before it sends anything. While status bit 0 (output full) is set, it reads the data port 0x68 and reads status again. If bit 0 is still set after `DRAIN_TRIES` (10) data reads, the block pulses `error` and writes nothing.
- R4: Status bit 1 (input full) must be seen clear before the command write to 0x6C, again after that write, and before each argument write to 0x68. Argument i is taken from `arg_bytes[8i+7:8i]`, and the arguments are written in increasing i.
- R5: A wait reads status. While the condition is not met and the remaining budget is non-zero, it waits `TICK_CYCLES` cycles, reduces the budget by one and reads again. A wait whose condition holds on the read after exactly `timeout_ms` failed polls succeeds.
- R6: If an input-full wait runs out of budget, the block pulses `error` and makes no further bus access.
- R7: For each response byte j, the block waits for status bit 0 set, then reads 0x68 into `resp_bytes[8j+7:8j]`. `resp_valid_cnt` counts the bytes stored.
- R8: If an output-full wait in the response phase runs out of budget, the block writes the command again at once, with no input-full wait first. It then resends all arguments and restarts the response count at 0.
- R9: At most `MAX_REPLAY` replays are made. A further output-full timeout pulses `error`, so the command is written `MAX_REPLAY`+1 times in total.
- R10: `slow_warn` pulses for one cycle when a wait succeeds, the latched timeout exceeds 20 ms and more than 20 ms of that wait have elapsed. No other case raises it.
- R11: A successful exchange ends with a one-cycle `done` pulse while `busy` falls. `done` and `error` are never high together.
- R12: `bus_req` stays high, with `bus_addr`, `bus_we` and `bus_wdata` stable, until `bus_ack`. Only 0x6C and 0x68 are ever addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange (ignored while busy) |
| cmd_byte | input | 8 | Command code |
| arg_count | input | $clog2(MAX_ARGS+1) | Number of argument bytes |
| arg_bytes | input | 8*MAX_ARGS | Argument bytes, byte i at bits 8i+7:8i |
| resp_count | input | $clog2(MAX_RESP+1) | Number of response bytes |
| timeout_ms | input | MS_W | Poll budget per wait, in ms (20 nominal) |
| bus_req | output | 1 | Port access request |
| bus_addr | output | 8 | Port address (0x6C or 0x68) |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete (one cycle) |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Success pulse |
| error | output | 1 | Failure pulse |
| slow_warn | output | 1 | Late-success warning pulse |
| resp_bytes | output | 8*MAX_RESP | Response bytes, byte j at bits 8j+7:8j |
| resp_valid_cnt | output | $clog2(MAX_RESP+1) | Response bytes stored |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and `MAX_REPLAY` = 2, with the other parameters at their defaults. A 4-cycle millisecond keeps waits of more than 20 ms, and timeouts at exactly the budget boundary, to a few hundred cycles. The slow-warning rule and the off-by-one edge of the poll budget can therefore be reached directly. The small replay limit means that running out of replays takes only three command writes against a controller model whose output flag never sets.

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq #(
  parameter int TICK_CYCLES = 1000,
  parameter int MAX_ARGS    = 16,
  parameter int MAX_RESP    = 16,
  parameter int MAX_REPLAY  = 4,
  parameter int DRAIN_TRIES = 10,
  parameter int BASE_MS     = 20,
  parameter int MS_W        = 16,
  parameter logic [7:0] CMD_PORT  = 8'h6C,
  parameter logic [7:0] DATA_PORT = 8'h68,
  localparam int AW = $clog2(MAX_ARGS + 1),
  localparam int RW = $clog2(MAX_RESP + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [7:0]            cmd_byte,
  input  logic [AW-1:0]         arg_count,
  input  logic [8*MAX_ARGS-1:0] arg_bytes,
  input  logic [RW-1:0]         resp_count,
  input  logic [MS_W-1:0]       timeout_ms,
  output logic                  bus_req,
  output logic [7:0]            bus_addr,
  output logic                  bus_we,
  output logic [7:0]            bus_wdata,
  input  logic                  bus_ack,
  input  logic [7:0]            bus_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic                  slow_warn,
  output logic [8*MAX_RESP-1:0] resp_bytes,
  output logic [RW-1:0]         resp_valid_cnt
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int PW = $clog2(MAX_REPLAY + 2);
  localparam int DW = $clog2(DRAIN_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DR_STAT, S_DR_DATA, S_POLL, S_DELAY, S_CMD, S_SEQ, S_ARG, S_RESP
  } st_t;

  st_t st, nxt_st;
  logic                  wait_obf;
  logic [7:0]            cmd_q;
  logic [8*MAX_ARGS-1:0] args_q;
  logic [AW-1:0]         argc_q, aidx;
  logic [RW-1:0]         respc_q, ridx;
  logic [MS_W-1:0]       lim_q, timeo;
  logic [TW-1:0]         dly;
  logic [DW-1:0]         drain_n;
  logic [PW-1:0]         replays;

  wire poll_ok = wait_obf ? bus_rdata[0] : !bus_rdata[1];
  wire [MS_W-1:0] elapsed = lim_q - timeo;

  assign busy           = (st != S_IDLE);
  assign resp_valid_cnt = ridx;
  assign bus_req  = (st == S_DR_STAT) || (st == S_DR_DATA) || (st == S_POLL) ||
                    (st == S_CMD) || (st == S_ARG) || (st == S_RESP);
  assign bus_addr = (st == S_DR_DATA || st == S_ARG || st == S_RESP) ? DATA_PORT : CMD_PORT;
  assign bus_we   = (st == S_CMD) || (st == S_ARG);
  assign bus_wdata = (st == S_CMD) ? cmd_q :
                     (st == S_ARG) ? args_q[aidx*8 +: 8] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt_st <= S_IDLE; wait_obf <= 1'b0;
      cmd_q <= '0; args_q <= '0; argc_q <= '0; respc_q <= '0; lim_q <= '0;
      timeo <= '0; dly <= '0; aidx <= '0; ridx <= '0; drain_n <= '0; replays <= '0;
      resp_bytes <= '0; done <= 1'b0; error <= 1'b0; slow_warn <= 1'b0;
    end else begin
      done <= 1'b0; error <= 1'b0; slow_warn <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cmd_q   <= cmd_byte;
          args_q  <= arg_bytes;
          argc_q  <= (arg_count > AW'(MAX_ARGS)) ? AW'(MAX_ARGS) : arg_count;
          respc_q <= (resp_count > RW'(MAX_RESP)) ? RW'(MAX_RESP) : resp_count;
          lim_q   <= timeout_ms;
          aidx <= '0; ridx <= '0; drain_n <= '0; replays <= '0;
          st <= S_DR_STAT;
        end
        S_DR_STAT: if (bus_ack) begin
          if (bus_rdata[0]) begin
            if (drain_n == DW'(DRAIN_TRIES)) begin error <= 1'b1; st <= S_IDLE; end
            else st <= S_DR_DATA;
          end else begin
            wait_obf <= 1'b0; nxt_st <= S_CMD; timeo <= lim_q; st <= S_POLL;
          end
        end
        S_DR_DATA: if (bus_ack) begin
          drain_n <= drain_n + 1'b1; st <= S_DR_STAT;
        end
        S_POLL: if (bus_ack) begin
          if (poll_ok) begin
            if (lim_q > MS_W'(BASE_MS) && elapsed > MS_W'(BASE_MS)) slow_warn <= 1'b1;
            st <= nxt_st;
          end else if (timeo == '0) begin
            if (wait_obf && replays != PW'(MAX_REPLAY)) begin
              replays <= replays + 1'b1; aidx <= '0; ridx <= '0; st <= S_CMD;
            end else begin
              error <= 1'b1; st <= S_IDLE;
            end
          end else begin
            dly <= '0; st <= S_DELAY;
          end
        end
        S_DELAY: if (dly == TW'(TICK_CYCLES - 1)) begin
          timeo <= timeo - 1'b1; st <= S_POLL;
        end else dly <= dly + 1'b1;
        S_CMD: if (bus_ack) begin
          wait_obf <= 1'b0; nxt_st <= S_SEQ; timeo <= lim_q; st <= S_POLL;
        end
        S_SEQ: begin
          if (aidx < argc_q) begin
            wait_obf <= 1'b0; nxt_st <= S_ARG; timeo <= lim_q; st <= S_POLL;
          end else if (ridx < respc_q) begin
            wait_obf <= 1'b1; nxt_st <= S_RESP; timeo <= lim_q; st <= S_POLL;
          end else begin
            done <= 1'b1; st <= S_IDLE;
          end
        end
        S_ARG: if (bus_ack) begin
          aidx <= aidx + 1'b1; st <= S_SEQ;
        end
        S_RESP: if (bus_ack) begin
          resp_bytes[ridx*8 +: 8] <= bus_rdata;
          ridx <= ridx + 1'b1; st <= S_SEQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  p_port_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr == CMD_PORT || bus_addr == DATA_PORT));
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  p_drain_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drain_n <= DW'(DRAIN_TRIES));
  p_replay_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    replays <= PW'(MAX_REPLAY));
  p_warn_long_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slow_warn |-> lim_q > MS_W'(BASE_MS));
  p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy && !(done && error));
endmodule

// File: tb/ec_cmd_seq_tb.sv
module ec_cmd_seq_tb_top;
  localparam int TICK = 4;
  localparam int NARG = 16;
  localparam int NRSP = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [4:0] arg_count = '0, resp_count = '0;
  logic [8*NARG-1:0] arg_bytes = '0;
  logic [15:0] timeout_ms = 16'd20;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic busy, done, error, slow_warn;
  logic [8*NRSP-1:0] resp_bytes;
  logic [4:0] resp_valid_cnt;

  always #2 clk = ~clk;

  ec_cmd_seq #(.TICK_CYCLES(TICK), .MAX_REPLAY(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_byte(cmd_byte),
    .arg_count(arg_count), .arg_bytes(arg_bytes), .resp_count(resp_count),
    .timeout_ms(timeout_ms), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .error(error),
    .slow_warn(slow_warn), .resp_bytes(resp_bytes), .resp_valid_cnt(resp_valid_cnt));

  int checks = 0, fails = 0, cycles = 0;

  // controller model
  int stale, k_ibf, ibf_cnt, m_obf, obf_wait, avail, ridx, stuck_left;
  int cmds_seen, args_total, drain_reads, stat_reads, warn_cnt;
  bit stuck, cmd_given;
  logic [7:0] last_cmd;
  logic [7:0] arg_log [$];

  always @(posedge clk) begin
    cycles++;
    if (slow_warn) warn_cnt++;
    if (!rst_n) bus_ack <= 1'b0;
    else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (bus_addr == 8'h6C && !bus_we) begin
          stat_reads++;
          bus_rdata <= {6'b0, ibf_cnt > 0,
                        (stale > 0) || (cmd_given && !stuck && ridx < avail && obf_wait == 0)};
          if (ibf_cnt > 0) ibf_cnt--;
          if (cmd_given && !stuck && obf_wait > 0) obf_wait--;
        end else if (bus_addr == 8'h6C) begin
          cmds_seen++; last_cmd = bus_wdata; ibf_cnt = k_ibf; stale = 0; cmd_given = 1;
          stuck = (stuck_left > 0); if (stuck_left > 0) stuck_left--;
          ridx = 0; obf_wait = m_obf;
        end else if (bus_we) begin
          arg_log.push_back(bus_wdata); args_total++; ibf_cnt = k_ibf;
        end else if (stale > 0) begin
          stale--; drain_reads++; bus_rdata <= 8'hEE;
        end else if (ridx < avail) begin
          bus_rdata <= 8'hA0 + 8'(ridx); ridx++; obf_wait = m_obf;
        end else bus_rdata <= 8'hFF;
      end
    end
  end

  // per-clock protocol comparison
  logic p_req = 0, p_ack = 0, p_we = 0;
  logic [7:0] p_addr = 0, p_wd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !p_ack) begin
        checks++;
        if (!(bus_req && bus_addr == p_addr && bus_we == p_we && bus_wdata == p_wd)) begin
          fails++;
          $display("FAIL R12 request dropped/changed: req=%0d addr=%h exp addr=%h", bus_req, bus_addr, p_addr);
        end
      end
      if (done && error) begin
        checks++; fails++;
        $display("FAIL R11 done and error together: act=1 exp=0");
      end
    end
    p_req = bus_req; p_ack = bus_ack; p_addr = bus_addr; p_we = bus_we; p_wd = bus_wdata;
  end

  always @(posedge clk) if (cycles > 150000) begin
    fails++;
    $display("FAIL watchdog expired: act=%0d cycles exp<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic ec_setup(input int st_n, input int k0, input int k, input int m,
                          input int av, input int stk);
    stale = st_n; ibf_cnt = k0; k_ibf = k; m_obf = m; obf_wait = m; avail = av;
    stuck_left = stk; stuck = 0; cmd_given = 0; ridx = 0;
    cmds_seen = 0; args_total = 0; drain_reads = 0; stat_reads = 0; warn_cnt = 0;
    arg_log.delete();
  endtask

  bit got_done, got_err;
  task automatic run(input logic [7:0] c, input int na, input int nr, input int lim);
    @(negedge clk);
    cmd_byte = c; arg_count = 5'(na); resp_count = 5'(nr); timeout_ms = 16'(lim);
    for (int i = 0; i < NARG; i++) arg_bytes[i*8 +: 8] = 8'h10 + 8'(i);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    got_done = 0; got_err = 0;
    while (!got_done && !got_err) begin
      @(negedge clk);
      got_done = done; got_err = error;
    end
  endtask

  initial begin
    ec_setup(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && !slow_warn && !bus_req && resp_valid_cnt == 0,
        "R1 reset outputs", int'(busy) + int'(bus_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R7 basic exchange
    ec_setup(0, 2, 1, 2, 2, 0);
    run(8'h55, 3, 2, 20);
    chk(got_done, "R11 basic done", got_done, 1);
    chk(cmds_seen == 1 && last_cmd == 8'h55, "R4 command written", last_cmd, 8'h55);
    chk(args_total == 3 && arg_log[0] == 8'h10 && arg_log[2] == 8'h12, "R4 argument order",
        args_total, 3);
    chk(resp_bytes[7:0] == 8'hA0 && resp_bytes[15:8] == 8'hA1, "R7 response bytes",
        resp_bytes[15:0], 16'hA1A0);
    chk(resp_valid_cnt == 2, "R7 valid count", resp_valid_cnt, 2);
    chk(!busy, "R11 busy falls", busy, 0);

    // R3 drain of stale bytes
    ec_setup(3, 0, 0, 0, 0, 0);
    run(8'h21, 0, 0, 20);
    chk(got_done && drain_reads == 3, "R3 stale drained", drain_reads, 3);

    // R3 drain overflow
    ec_setup(12, 0, 0, 0, 0, 0);
    run(8'h22, 0, 0, 20);
    chk(got_err && drain_reads == 10, "R3 drain limit error", drain_reads, 10);
    chk(cmds_seen == 0, "R3 no command after drain error", cmds_seen, 0);

    // R6 IBF timeout
    ec_setup(0, 0, 6, 0, 0, 0);
    run(8'h23, 2, 0, 5);
    chk(got_err, "R6 ibf timeout error", got_err, 1);
    chk(cmds_seen == 1 && args_total == 0, "R6 no writes after timeout", args_total, 0);

    // R5 success at the exact budget
    ec_setup(0, 0, 5, 0, 0, 0);
    run(8'h24, 0, 0, 5);
    chk(got_done, "R5 success at limit", got_done, 1);
    chk(stat_reads == 8, "R5 status read count", stat_reads, 8);
    chk(warn_cnt == 0, "R10 no warn under short limit", warn_cnt, 0);

    // R10 slow warning
    ec_setup(0, 0, 22, 0, 0, 0);
    run(8'h25, 0, 0, 30);
    chk(got_done && warn_cnt == 1, "R10 slow warning", warn_cnt, 1);
    ec_setup(0, 0, 20, 0, 0, 0);
    run(8'h26, 0, 0, 30);
    chk(got_done && warn_cnt == 0, "R10 no warn at 20 ms", warn_cnt, 0);
    ec_setup(0, 0, 20, 0, 0, 0);
    run(8'h27, 0, 0, 20);
    chk(got_done && warn_cnt == 0, "R10 no warn at base limit", warn_cnt, 0);

    // R8 replay
    ec_setup(0, 0, 0, 0, 1, 1);
    run(8'h28, 2, 1, 3);
    chk(got_done && cmds_seen == 2, "R8 command replayed", cmds_seen, 2);
    chk(args_total == 4, "R8 arguments resent", args_total, 4);
    chk(resp_bytes[7:0] == 8'hA0 && resp_valid_cnt == 1, "R8 response after replay",
        resp_valid_cnt, 1);

    // R9 replay exhausted
    ec_setup(0, 0, 0, 0, 1, 100);
    run(8'h29, 0, 1, 1);
    chk(got_err && cmds_seen == 3, "R9 replay limit", cmds_seen, 3);

    // R2 start while busy ignored
    ec_setup(0, 0, 3, 0, 0, 0);
    @(negedge clk);
    cmd_byte = 8'h5A; arg_count = 0; resp_count = 0; timeout_ms = 16'd20;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy, "R2 busy after start", busy, 1);
    repeat (3) @(negedge clk);
    cmd_byte = 8'h99; start = 1'b1; @(negedge clk); start = 1'b0;
    while (!done && !error) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(cmds_seen == 1 && last_cmd == 8'h5A && !busy, "R2 start ignored while busy",
        last_cmd, 8'h5A);

    // R7 zero-length exchange
    ec_setup(0, 0, 0, 0, 0, 0);
    run(8'h2A, 0, 0, 20);
    chk(got_done && resp_valid_cnt == 0 && args_total == 0, "R7 empty exchange",
        resp_valid_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule